// File: doc/BRIEF.md
# Converter Result Capture and Pixel Alignment

This block sits between an external pipelined image converter and the on-chip pixel datapath. The converter reports each 14-bit straight-binary result, a single out-of-range bit and a data-valid strobe. Because of the converter's internal pipeline, every result belongs to the conversion started four start-convert pulses before the latest one. The block counts start-convert rising edges to give each conversion a pixel index. When a result arrives, the block attaches the matching older index to it, so that data and pixel line up again.

Both converter strobes cross into the local clock through two-flop synchronizers. A result is taken on the synchronized rising edge of the data-valid strobe. Results that arrive before the converter pipeline holds any real conversion are discarded. The out-of-range bit is split into separate over-range and under-range flags using the result's MSB. The block never pushes back on the converter. If the single output slot is still occupied when a new result is due, that result is lost and a sticky flag records the loss.

Top module: `pix_result_capture`

## Requirements
- R1: Start-convert rising edges are numbered from 0 after reset. Each delivered word carries the index of the start issued four starts before the most recent one (index = starts seen − 5, modulo 2^PIX_W).
- R2: Results captured before five start edges have been seen are discarded. No word is delivered for them and the overflow flag is not touched.
- R3: The 14-bit result is delivered unchanged in straight binary, with all ones for full scale and all zeros for zero.
- R4: Range flags: out-of-range=0 gives neither flag. Out-of-range=1 with data bit 13 = 1 gives over-range only. Out-of-range=1 with bit 13 = 0 gives under-range only.
- R5: out_valid_o rises on the third rising clock edge that samples the data-valid strobe high, counting the first one. A strobe held high for many cycles yields exactly one word.
- R6: While out_valid_o is high and out_ready_i is low, the data, index and flags hold steady.
- R7: A result that arrives while the slot holds an unaccepted word is dropped, and the held word is kept. overflow_o then rises and stays high until reset. The converter is never stalled.
- R8: After reset, out_valid_o and overflow_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Start-convert pulse, asynchronous |
| adc_dv_i | input | 1 | Converter data-valid strobe, asynchronous |
| adc_data_i | input | DATA_W | Converter result, stable around the strobe |
| adc_oor_i | input | 1 | Converter out-of-range bit |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Delivered result |
| out_pix_o | output | PIX_W | Pixel index of the result |
| out_over_o | output | 1 | Over-range flag |
| out_under_o | output | 1 | Under-range flag |
| overflow_o | output | 1 | Sticky lost-result flag |

## Verification
A word is due on the third clock edge after the data-valid strobe is first sampled high, after two synchronizer flops and the capture register. The bench drives inputs on falling edges and checks for out_valid_o low on the first two falling edges after the strobe rises and high on the third. Start pulses and strobes are spaced six cycles apart, so each start edge reaches the tracker before the next strobe edge is seen. The scoreboard pushes an expected word only once five starts have been issued and no stall is pending. A monitor compares each handshake on the falling edge where valid and ready are both high.

// File: rtl/pix_cap_pkg.sv
package pix_cap_pkg;

  typedef enum logic [1:0] {
    RNG_IN    = 2'b00,
    RNG_UNDER = 2'b01,
    RNG_OVER  = 2'b10
  } rng_e;

  // oor flag plus result MSB -> range class
  function automatic rng_e classify(input logic oor, input logic msb);
    if (!oor)    return RNG_IN;
    else if (msb) return RNG_OVER;
    else          return RNG_UNDER;
  endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pix_tag_tracker.sv
module pix_tag_tracker #(
  parameter int PIX_W = 12,
  parameter int LAT   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [PIX_W-1:0] owner_o,
  output logic             owner_vld_o
);
  localparam int TAPS = LAT + 1;

  logic [PIX_W-1:0] cnt_q;
  logic [PIX_W-1:0] tag_q [TAPS];
  logic [TAPS-1:0]  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= '0;
      for (int i = 0; i < TAPS; i++) tag_q[i] <= '0;
    end else if (start_i) begin
      cnt_q    <= cnt_q + 1'b1;
      tag_q[0] <= cnt_q;
      for (int i = 1; i < TAPS; i++) tag_q[i] <= tag_q[i-1];
      vld_q    <= {vld_q[TAPS-2:0], 1'b1};
    end
  end

  assign owner_o     = tag_q[LAT];
  assign owner_vld_o = vld_q[LAT];

  // oldest tap trails the newest by exactly LAT conversions
  p_tag_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_vld_o |-> (tag_q[0] - tag_q[LAT]) == PIX_W'(LAT));

  p_fill_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_vld_o |-> vld_q[0]);

endmodule

// File: rtl/out_slot.sv
module out_slot #(
  parameter int DATA_W = 14,
  parameter int PIX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              over_i,
  input  logic              under_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              over_o,
  output logic              under_o,
  output logic              overflow_o
);
  logic busy;
  assign busy = valid_o & ~ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      data_o     <= '0;
      pix_o      <= '0;
      over_o     <= 1'b0;
      under_o    <= 1'b0;
      overflow_o <= 1'b0;
    end else if (load_i) begin
      if (busy) begin
        overflow_o <= 1'b1;
      end else begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        pix_o   <= pix_i;
        over_o  <= over_i;
        under_o <= under_i;
      end
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(pix_o)
                               && $stable(over_o) && $stable(under_o)));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_ovf_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(busy));

  p_range_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over_o && under_o));

endmodule

// File: rtl/pix_result_capture.sv
module pix_result_capture
  import pix_cap_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int PIX_W     = 12,
  parameter int LAT       = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              adc_dv_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              adc_oor_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [PIX_W-1:0]  out_pix_o,
  output logic              out_over_o,
  output logic              out_under_o,
  output logic              overflow_o
);
  localparam int MSB = DATA_W - 1;

  logic             start_rise, cap_rise;
  logic [PIX_W-1:0] owner;
  logic             owner_vld;
  logic             load;
  rng_e             rng;

  sync_edge #(.STAGES(SYNC_STGS)) u_start_sync (
    .clk_i, .rst_ni, .async_i(conv_start_i), .rise_o(start_rise));

  sync_edge #(.STAGES(SYNC_STGS)) u_dv_sync (
    .clk_i, .rst_ni, .async_i(adc_dv_i), .rise_o(cap_rise));

  pix_tag_tracker #(.PIX_W(PIX_W), .LAT(LAT)) u_tracker (
    .clk_i, .rst_ni, .start_i(start_rise),
    .owner_o(owner), .owner_vld_o(owner_vld));

  assign rng  = classify(adc_oor_i, adc_data_i[MSB]);
  assign load = cap_rise & owner_vld;

  out_slot #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_slot (
    .clk_i, .rst_ni,
    .load_i(load), .data_i(adc_data_i), .pix_i(owner),
    .over_i(rng == RNG_OVER), .under_i(rng == RNG_UNDER),
    .ready_i(out_ready_i),
    .valid_o(out_valid_o), .data_o(out_data_o), .pix_o(out_pix_o),
    .over_o(out_over_o), .under_o(out_under_o), .overflow_o(overflow_o));

  p_prefill_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_rise && !owner_vld && !out_valid_o) |=> !out_valid_o);

  p_cap_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_rise && owner_vld && !(out_valid_o && !out_ready_i)) |=> out_valid_o);

  p_prefill_no_ovf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_rise && !owner_vld && !overflow_o) |=> !overflow_o);

endmodule

// File: tb/tb_pix_result_capture.sv
module tb_pix_result_capture;
  localparam int DW = 14;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, dv = 1'b0, oor = 1'b0, ready = 1'b1;
  logic [DW-1:0] data = '0;
  logic          vld, over, under, ovf;
  logic [DW-1:0] odata;
  logic [PW-1:0] opix;

  int checks = 0, errors = 0, starts = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [DW-1:0] d;
    logic [PW-1:0] p;
    logic          o;
    logic          u;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  pix_result_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(start), .adc_dv_i(dv),
    .adc_data_i(data), .adc_oor_i(oor), .out_valid_o(vld), .out_ready_i(ready),
    .out_data_o(odata), .out_pix_o(opix), .out_over_o(over),
    .out_under_o(under), .overflow_o(ovf));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: one handshake per falling edge
  always @(negedge clk) begin
    if (rst_n && vld && ready) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected word actual=%0h expected=none", odata);
      end else begin
        e = exp_q.pop_front();
        chk(odata == e.d, "R3 data", odata, e.d);
        chk(opix == e.p, "R1 pixel", opix, e.p);
        chk({over, under} == {e.o, e.u}, "R4 range", {over, under}, {e.o, e.u});
      end
    end
  end

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    starts++;
  endtask

  task automatic do_result(input logic [DW-1:0] d, input logic r, input int hold,
                           input bit drop, input bit timed);
    exp_t e;
    @(negedge clk);
    data = d; oor = r; dv = 1'b1;
    if (starts >= 5 && !drop) begin
      e.d = d; e.p = PW'(starts - 5); e.o = r & d[DW-1]; e.u = r & ~d[DW-1];
      exp_q.push_back(e);
    end
    if (timed) begin
      @(negedge clk); chk(vld == 1'b0, "R5 early1", vld, 0);
      @(negedge clk); chk(vld == 1'b0, "R5 early2", vld, 0);
      @(negedge clk); chk(vld == 1'b1, "R5 due", vld, 1);
      repeat (hold - 3) @(negedge clk);
    end else begin
      repeat (hold) @(negedge clk);
    end
    dv = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_pixel(input logic [DW-1:0] d, input logic r);
    do_start();
    do_result(d, r, 3, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R8 valid", vld, 0);
    chk(ovf == 1'b0, "R8 overflow", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0, "R8 valid after release", vld, 0);

    // R2: pipeline filling, four results discarded
    for (int i = 0; i < 4; i++) do_pixel(DW'(100 + i), 1'b1);
    chk(vld == 1'b0, "R2 nothing delivered", vld, 0);
    chk(ovf == 1'b0, "R2 no overflow", ovf, 0);

    // R1 R3 R4: patterns
    do_pixel(14'h3FFF, 1'b1);  // over
    do_pixel(14'h0000, 1'b1);  // under
    do_pixel(14'h2000, 1'b0);  // in range msb set
    do_pixel(14'h1FFF, 1'b0);  // in range msb clear
    do_pixel(14'h3FFF, 1'b0);  // full scale
    do_pixel(14'h0001, 1'b0);
    do_pixel(14'h0000, 1'b0);
    do_pixel(14'h1234, 1'b1);  // under
    for (int i = 0; i < 6; i++) do_pixel(DW'(i * 2731), i[0]);

    // R5: latency and long strobe gives one word
    do_start();
    do_result(14'h0ABC, 1'b0, 4, 1'b0, 1'b1);
    do_start();
    do_result(14'h2D2D, 1'b1, 12, 1'b0, 1'b0);

    // R6 R7: stall, second result lost
    @(negedge clk); ready = 1'b0;
    do_start();
    do_result(14'h1111, 1'b0, 3, 1'b0, 1'b0);
    chk(vld == 1'b1 && odata == 14'h1111, "R6 held word", odata, 14'h1111);
    chk(ovf == 1'b0, "R7 no overflow yet", ovf, 0);
    do_start();
    do_result(14'h2222, 1'b0, 3, 1'b1, 1'b0);
    chk(ovf == 1'b1, "R7 overflow set", ovf, 1);
    chk(odata == 14'h1111, "R6 R7 held word kept", odata, 14'h1111);
    @(negedge clk); ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(ovf == 1'b1, "R7 sticky", ovf, 1);

    do_pixel(14'h0777, 1'b0);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
    chk(ovf == 1'b1, "R7 still sticky", ovf, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule